// File: doc/BRIEF.md
# Receive Timestamp Header Inserter

This block sits in a receive datapath between the frame source and the packet-buffer writer. When a new frame arrives on a queue that has timestamping enabled, the block samples two free-running time-of-day clocks. Each clock gives a nanoseconds word and a seconds word. The block then emits a 16-byte header, four 32-bit words, ahead of the frame's own beats. Frames on disabled queues, or frames arriving while either global switch is off, pass through untouched.

Each queue chooses, for each of the two header slots, which timer feeds that slot. The front slot fills words 0 and 1 and the back slot fills words 2 and 3. A select value of 1 picks timer 1 and a value of 0 picks timer 0. With the usual setting (front = 1, back = 0) the header reads: timer-1 nanoseconds, timer-1 seconds, timer-0 nanoseconds, timer-0 seconds. Both the input and output sides are 32-bit valid/ready streams carrying an end-of-frame flag. Byte lane 0 (`tdata[7:0]`) is the first byte in memory.

Top module: `rxts_prepend`

## Requirements
- R1: After reset, with no input offered, `m_tvalid` and `m_tlast` are 0.
- R2: An inserted header is exactly four words emitted before the first frame beat. Word 0 is the front slot's nanoseconds, word 1 the front slot's seconds, word 2 the back slot's nanoseconds and word 3 the back slot's seconds.
- R3: Each header word is little-endian on the stream: the least significant byte of the value travels in byte lane 0 (`m_tdata[7:0]`), and the most significant byte travels in lane 3.
- R4: For the queue given by `s_queue` on the first beat, `cfg_front_sel[q]` selects the timer for the front slot and `cfg_back_sel[q]` selects the timer for the back slot (0 = timer 0, 1 = timer 1).
- R5: A header is inserted only when `cfg_rx_ts_on`, `cfg_buf_ts_on` and `cfg_q_en[q]` are all 1. Otherwise every frame beat passes through with data and last unchanged, and no extra words appear.
- R6: Both timers are sampled in the cycle in which the frame's first beat is first presented while the block is between frames. Timer changes after that cycle do not alter the header.
- R7: While `m_tready` is low, a presented header word stays valid and stable. No input beat is accepted while header words are still pending.
- R8: Header words never assert `m_tlast`. The last output beat of a frame is the frame's own last beat.
- R9: A single-beat frame receives a full header when enabled and passes alone when not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rx_ts_on | input | 1 | Global receive timestamp switch |
| cfg_buf_ts_on | input | 1 | Global packet-buffer timestamp switch |
| cfg_q_en | input | NQ | Per-queue header enable |
| cfg_front_sel | input | NQ | Per-queue timer select for words 0-1 |
| cfg_back_sel | input | NQ | Per-queue timer select for words 2-3 |
| tmr0_ns | input | TW | Timer 0 nanoseconds |
| tmr0_sec | input | TW | Timer 0 seconds |
| tmr1_ns | input | TW | Timer 1 nanoseconds |
| tmr1_sec | input | TW | Timer 1 seconds |
| s_queue | input | QW | Queue index, valid with the first beat |
| s_tdata | input | TW | Input frame data |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tlast | input | 1 | Input end-of-frame |
| m_tdata | output | TW | Output data |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output sink ready |
| m_tlast | output | 1 | Output end-of-frame |

## Verification
Pass-through beats reach the output in the same cycle, because the data path is combinational in that state. Header word 0 appears one cycle after the first beat is presented, since the timer sample is registered. Each further header word follows in the next cycle in which `m_tready` is high, and the held first beat then passes in the cycle after word 3 is accepted. The bench does not count cycles. It compares each output handshake in order against a queue of expected beats, which makes these fixed latencies irrelevant to the comparison. It drives inputs at the falling edge and samples just before the rising edge, where each handshake takes effect.

// File: rtl/rxts_pkg.sv
package rxts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_DATA = 2'd2
    } rxts_state_e;

    localparam int HDR_WORDS = 4;
    localparam int HDR_SLOTS = 2;
endpackage

// File: rtl/rxts_q_cfg.sv
module rxts_q_cfg #(
    parameter int NQ = 4,
    parameter int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          rx_on,
    input  logic          buf_on,
    input  logic [NQ-1:0] q_en,
    input  logic [NQ-1:0] front_sel,
    input  logic [NQ-1:0] back_sel,
    input  logic [QW-1:0] q,
    output logic          ins,
    output logic          front_o,
    output logic          back_o
);
    always_comb begin
        ins     = 1'b0;
        front_o = 1'b0;
        back_o  = 1'b0;
        for (int i = 0; i < NQ; i++) begin
            if (QW'(i) == q) begin
                ins     = rx_on & buf_on & q_en[i];
                front_o = front_sel[i];
                back_o  = back_sel[i];
            end
        end
    end
endmodule

// File: rtl/rxts_hdr_build.sv
module rxts_hdr_build #(
    parameter int TW = 32
) (
    input  logic                              front_sel,
    input  logic                              back_sel,
    input  logic [TW-1:0]                     t0_ns,
    input  logic [TW-1:0]                     t0_sec,
    input  logic [TW-1:0]                     t1_ns,
    input  logic [TW-1:0]                     t1_sec,
    output logic [rxts_pkg::HDR_WORDS-1:0][TW-1:0] words
);
    localparam int NB = TW / 8;

    logic [rxts_pkg::HDR_SLOTS-1:0] sel;
    assign sel = {back_sel, front_sel};

    for (genvar s = 0; s < rxts_pkg::HDR_SLOTS; s++) begin : g_slot
        logic [TW-1:0] ns_v, sec_v;
        assign ns_v  = sel[s] ? t1_ns  : t0_ns;
        assign sec_v = sel[s] ? t1_sec : t0_sec;
        // little-endian lane order: value byte b goes to lane b
        for (genvar b = 0; b < NB; b++) begin : g_lane
            assign words[2*s][8*b +: 8]   = ns_v[8*b +: 8];
            assign words[2*s+1][8*b +: 8] = sec_v[8*b +: 8];
        end
    end
endmodule

// File: rtl/rxts_prepend.sv
module rxts_prepend #(
    parameter int NQ = 4,
    parameter int TW = 32,
    parameter int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_rx_ts_on,
    input  logic          cfg_buf_ts_on,
    input  logic [NQ-1:0] cfg_q_en,
    input  logic [NQ-1:0] cfg_front_sel,
    input  logic [NQ-1:0] cfg_back_sel,
    input  logic [TW-1:0] tmr0_ns,
    input  logic [TW-1:0] tmr0_sec,
    input  logic [TW-1:0] tmr1_ns,
    input  logic [TW-1:0] tmr1_sec,
    input  logic [QW-1:0] s_queue,
    input  logic [TW-1:0] s_tdata,
    input  logic          s_tvalid,
    output logic          s_tready,
    input  logic          s_tlast,
    output logic [TW-1:0] m_tdata,
    output logic          m_tvalid,
    input  logic          m_tready,
    output logic          m_tlast
);
    import rxts_pkg::*;

    localparam int IW = $clog2(HDR_WORDS);

    typedef struct packed {
        rxts_state_e                 st;
        logic [IW-1:0]               idx;
        logic [HDR_WORDS-1:0][TW-1:0] hdr;
    } regs_t;

    regs_t r_q, r_d;

    logic ins, fsel, bsel;
    logic [HDR_WORDS-1:0][TW-1:0] built;

    rxts_q_cfg #(.NQ(NQ), .QW(QW)) u_cfg (
        .rx_on    (cfg_rx_ts_on),
        .buf_on   (cfg_buf_ts_on),
        .q_en     (cfg_q_en),
        .front_sel(cfg_front_sel),
        .back_sel (cfg_back_sel),
        .q        (s_queue),
        .ins      (ins),
        .front_o  (fsel),
        .back_o   (bsel)
    );

    rxts_hdr_build #(.TW(TW)) u_build (
        .front_sel(fsel),
        .back_sel (bsel),
        .t0_ns    (tmr0_ns),
        .t0_sec   (tmr0_sec),
        .t1_ns    (tmr1_ns),
        .t1_sec   (tmr1_sec),
        .words    (built)
    );

    always_comb begin
        r_d      = r_q;
        s_tready = 1'b0;
        m_tvalid = 1'b0;
        m_tdata  = s_tdata;
        m_tlast  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (s_tvalid && ins) begin
                    // sample both timers now; hold the first beat
                    r_d.st  = ST_HDR;
                    r_d.idx = '0;
                    r_d.hdr = built;
                end else begin
                    m_tvalid = s_tvalid;
                    m_tlast  = s_tlast;
                    s_tready = m_tready;
                    if (s_tvalid && m_tready && !s_tlast) r_d.st = ST_DATA;
                end
            end
            ST_HDR: begin
                m_tvalid = 1'b1;
                m_tdata  = r_q.hdr[r_q.idx];
                if (m_tready) begin
                    r_d.idx = r_q.idx + 1'b1;
                    if (r_q.idx == IW'(HDR_WORDS - 1)) r_d.st = ST_DATA;
                end
            end
            default: begin
                m_tvalid = s_tvalid;
                m_tlast  = s_tlast;
                s_tready = m_tready;
                if (s_tvalid && m_tready && s_tlast) r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st  <= ST_IDLE;
            r_q.idx <= '0;
            r_q.hdr <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    // R8 / R7: header beats carry no last and block the input side
    p_hdr_no_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HDR) |-> (m_tvalid && !m_tlast && !s_tready));

    // R7: a stalled header word is held
    p_hdr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HDR && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

    // R6: sampled timer words never change once a frame is under way
    p_sample_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE) |=> $stable(r_q.hdr));

    // R5: disabled frames pass untouched
    p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && s_tvalid && !ins)
            |-> (m_tvalid && m_tdata == s_tdata && m_tlast == s_tlast));

    // R2: an enabled first beat starts header emission
    p_start_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && s_tvalid && ins) |=> (r_q.st == ST_HDR && r_q.idx == '0));

    // R1: quiet output after reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && !s_tvalid) |-> (!m_tvalid && !m_tlast));
endmodule

// File: tb/rxts_prepend_bench.sv
`timescale 1ns/1ps
module rxts_prepend_bench;
    localparam int NQ = 4;
    localparam int TW = 32;
    localparam int QW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_on, buf_on;
    logic [NQ-1:0] qen, fsel, bsel;
    logic [TW-1:0] t0n, t0s, t1n, t1s;
    logic [QW-1:0] s_queue;
    logic [TW-1:0] s_tdata, m_tdata;
    logic s_tvalid, s_tready, s_tlast, m_tvalid, m_tready, m_tlast;

    int total = 0;
    int bad = 0;
    bit bp = 0;
    bit running = 0;
    logic [15:0] lfsr = 16'hACE1;

    typedef struct {
        logic [TW-1:0] d;
        logic          l;
        bit            hdr;
        string         tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    rxts_prepend #(.NQ(NQ), .TW(TW), .QW(QW)) u_rxts_prepend (
        .clk(clk), .rst_n(rst_n),
        .cfg_rx_ts_on(rx_on), .cfg_buf_ts_on(buf_on),
        .cfg_q_en(qen), .cfg_front_sel(fsel), .cfg_back_sel(bsel),
        .tmr0_ns(t0n), .tmr0_sec(t0s), .tmr1_ns(t1n), .tmr1_sec(t1s),
        .s_queue(s_queue), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
        .s_tready(s_tready), .s_tlast(s_tlast),
        .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready),
        .m_tlast(m_tlast)
    );

    // free-running timers and sink readiness, changed at the falling edge
    always @(negedge clk) begin
        t0n = t0n + 32'h0102_0305;
        t0s = t0s + 32'h0000_0001;
        t1n = t1n + 32'h1103_0709;
        t1s = t1s + 32'h0000_0003;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        m_tready = bp ? lfsr[0] : 1'b1;
    end

    task automatic check(input bit ok, input string tag,
                         input logic [TW-1:0] got, input logic [TW-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic push(input logic [TW-1:0] d, input logic l, input bit h, input string t);
        exp_t e;
        e.d = d; e.l = l; e.hdr = h; e.tag = t;
        sb.push_back(e);
    endtask

    task automatic send_frame(input int qi, input int n, input logic [TW-1:0] base);
        for (int b = 0; b < n; b++) begin
            @(negedge clk);
            s_queue  = QW'(qi);
            s_tdata  = base + TW'(b);
            s_tlast  = (b == n - 1);
            s_tvalid = 1'b1;
            #2;
            if (b == 0 && rx_on && buf_on && qen[qi]) begin
                // R2 R4 R6: header from timers seen in this cycle
                push(fsel[qi] ? t1n : t0n, 1'b0, 1, "R2 R4 R6 header word 0");
                push(fsel[qi] ? t1s : t0s, 1'b0, 1, "R2 R4 R6 header word 1");
                push(bsel[qi] ? t1n : t0n, 1'b0, 1, "R2 R4 R6 header word 2");
                push(bsel[qi] ? t1s : t0s, 1'b0, 1, "R2 R4 R6 header word 3");
            end
            if (n == 1)
                push(base, 1'b1, 0, "R9 R8 single-beat frame");
            else
                push(base + TW'(b), (b == n - 1), 0, "R5 R8 frame beat");
            while (!s_tready) begin
                @(negedge clk);
                #2;
            end
        end
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tlast  = 1'b0;
    endtask

    // monitor: samples just before the rising edge
    logic          pv, pr;
    logic [TW-1:0] pd;
    always @(negedge clk) begin
        #2;
        if (rst_n && running) begin
            if (pv && !pr)
                check(m_tvalid && m_tdata == pd, "R7 stalled beat held", m_tdata, pd);
            if (m_tvalid && sb.size() != 0 && sb[0].hdr)
                check(!s_tready, "R7 input blocked during header", {31'b0, s_tready}, 0);
            if (m_tvalid && m_tready) begin
                if (sb.size() == 0) begin
                    check(0, "R5 unexpected output beat", m_tdata, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(m_tdata == e.d, e.tag, m_tdata, e.d);
                    check(m_tlast == e.l, {e.tag, " last (R8)"}, {31'b0, m_tlast}, {31'b0, e.l});
                    if (e.hdr)
                        check(m_tdata[7:0] == e.d[7:0], "R3 lane 0 holds low byte",
                              {24'b0, m_tdata[7:0]}, {24'b0, e.d[7:0]});
                end
            end
            pv = m_tvalid; pr = m_tready; pd = m_tdata;
        end else begin
            pv = 1'b0; pr = 1'b1; pd = '0;
        end
    end

    bit done = 0;
    initial begin
        #(5ns * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rx_on = 1; buf_on = 1; qen = 4'b0111;
        fsel = 4'b1101; bsel = 4'b0110;
        t0n = 32'h1000_0000; t0s = 32'h0000_0100;
        t1n = 32'h2000_0000; t1s = 32'h0000_0200;
        s_queue = '0; s_tdata = '0; s_tvalid = 0; s_tlast = 0; m_tready = 1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #2;
        check(!m_tvalid && !m_tlast, "R1 idle after reset", {30'b0, m_tvalid, m_tlast}, 0);
        running = 1;

        send_frame(0, 3, 32'hA000_0000);     // front timer1, back timer0
        send_frame(1, 2, 32'hA100_0000);     // R4 swapped selects
        send_frame(2, 3, 32'hA200_0000);     // R4 both timer1
        send_frame(3, 2, 32'hA300_0000);     // R5 queue disabled
        rx_on = 0;
        send_frame(0, 2, 32'hA400_0000);     // R5 receive switch off
        rx_on = 1; buf_on = 0;
        send_frame(1, 1, 32'hA500_0000);     // R5 R9 buffer switch off
        buf_on = 1;
        send_frame(0, 1, 32'hA600_0000);     // R9 enabled single beat
        bp = 1;
        for (int k = 0; k < 12; k++)
            send_frame(k % NQ, 1 + (k % 5), 32'hB000_0000 + TW'(k << 8)); // R6 R7
        bp = 0;
        repeat (40) @(negedge clk);
        check(sb.size() == 0, "R2 all expected beats emitted", sb.size(), 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule